// File: doc/BRIEF.md
# Integer Execution Unit for a Load-Store RISC Subset

This block is the arithmetic and logic stage of a small 32-bit load-store integer pipeline. Each cycle it receives the primary opcode and the function code of an instruction, two register operands, the shift-amount field and the 16-bit immediate field. From these it forms one result word and a flag that tells whether that word is all zeros. The branch-on-equal path reads this flag after a subtract.

A small field decoder turns the opcode and function code into an internal operation select. That select steers an adder/subtractor with a signed less-than compare, a bitwise unit and a zero-filling barrel shifter. The immediate is extended according to the operation. A clocked output stage holds the result and the flag, so the unit has a latency of one cycle. Operand width, immediate width and the way the shifter and the compare are built are all parameters.

Top module: `exec_alu_core`

## Requirements
- R1: A synchronous reset, sampled high at a rising edge, sets `result_q` to 0 and `zero_q` to 1 after that edge.
- R2: With opcode 0, function code 32 gives `src_a + src_b` and function code 34 gives `src_a - src_b`, both modulo 2^32.
- R3: With opcode 0, function code 36 gives `src_a & src_b`, 37 gives `src_a | src_b`, and 39 gives `~(src_a | src_b)`.
- R4: With opcode 0, function code 42 gives 1 when `src_a` is less than `src_b` as signed two's-complement numbers, and 0 otherwise. Bits 31:1 are always 0.
- R5: With opcode 0, function code 0 shifts `src_b` left by `shamt`, and function code 2 shifts it right by `shamt`. Both fill the vacated bits with zeros. `src_a` has no effect on either.
- R6: Opcode 8 gives `src_a` plus the sign-extended immediate. Opcode 10 gives 1 when `src_a` is signed-less-than the sign-extended immediate, and 0 otherwise.
- R7: Opcode 12 gives `src_a` AND the zero-extended immediate. Opcode 13 gives `src_a` OR the zero-extended immediate.
- R8: Opcode 15 gives the immediate in bits 31:16 and zeros in bits 15:0. For example, immediate 255 gives 0x00FF0000.
- R9: `zero_q` is 1 exactly when `result_q` is all zeros.
- R10: The outputs after a rising edge reflect the inputs sampled at that edge, which is a latency of one cycle.
- R11: Any opcode or function-code combination not listed above gives a result of 0, so `zero_q` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Primary opcode field |
| funct | input | 6 | Function code field, used when opcode is 0 |
| src_a | input | DATA_W (32) | First register operand |
| src_b | input | DATA_W (32) | Second register operand, also the shift source |
| shamt | input | log2(DATA_W) (5) | Shift amount field |
| imm | input | IMM_W (16) | Immediate field |
| result_q | output | DATA_W (32) | Registered result |
| zero_q | output | 1 | Registered flag, high when the result is all zeros |

## Verification
The bench builds two copies of the unit at 32-bit operands and a 16-bit immediate, and drives both from the same inputs. The first copy uses the logarithmic shifter and derives less-than from the sign of the difference. The second uses the direct shift operators and a signed comparison. Comparing both copies against one reference shows that either build choice produces the same results, including the case where signed compares of operands with opposite signs overflow the subtractor. The 32-bit width puts the 31-position shift, the 0x7FFFFFFF wrap and the sign extension of 0x8000 and 0xFFFF within reach.

// File: rtl/exec_alu_pkg.sv
package exec_alu_pkg;

   // Opcode values (fixed by the instruction encoding)
   localparam logic [5:0] OPC_REG  = 6'd0;
   localparam logic [5:0] OPC_ADDI = 6'd8;
   localparam logic [5:0] OPC_SLTI = 6'd10;
   localparam logic [5:0] OPC_ANDI = 6'd12;
   localparam logic [5:0] OPC_ORI  = 6'd13;
   localparam logic [5:0] OPC_LUI  = 6'd15;

   // Function code values for register-register operations
   localparam logic [5:0] FN_SLL = 6'd0;
   localparam logic [5:0] FN_SRL = 6'd2;
   localparam logic [5:0] FN_ADD = 6'd32;
   localparam logic [5:0] FN_SUB = 6'd34;
   localparam logic [5:0] FN_AND = 6'd36;
   localparam logic [5:0] FN_OR  = 6'd37;
   localparam logic [5:0] FN_NOR = 6'd39;
   localparam logic [5:0] FN_SLT = 6'd42;

   typedef enum logic [3:0] {
      XOP_NONE,
      XOP_ADD,
      XOP_SUB,
      XOP_AND,
      XOP_OR,
      XOP_NOR,
      XOP_SLT,
      XOP_SLL,
      XOP_SRL,
      XOP_HIGH
   } xop_e;

   typedef enum logic [1:0] {
      BSRC_REG,
      BSRC_SEXT,
      BSRC_ZEXT
   } bsrc_e;

   typedef struct packed {
      xop_e  op;
      bsrc_e bsrc;
   } xctrl_t;

endpackage

// File: rtl/exec_alu_decode.sv
module exec_alu_decode
   import exec_alu_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output xctrl_t     ctrl
);

   xctrl_t reg_ctrl;

   always_comb begin
      reg_ctrl.bsrc = BSRC_REG;
      unique case (funct)
         FN_ADD:  reg_ctrl.op = XOP_ADD;
         FN_SUB:  reg_ctrl.op = XOP_SUB;
         FN_AND:  reg_ctrl.op = XOP_AND;
         FN_OR:   reg_ctrl.op = XOP_OR;
         FN_NOR:  reg_ctrl.op = XOP_NOR;
         FN_SLT:  reg_ctrl.op = XOP_SLT;
         FN_SLL:  reg_ctrl.op = XOP_SLL;
         FN_SRL:  reg_ctrl.op = XOP_SRL;
         default: reg_ctrl.op = XOP_NONE;
      endcase
   end

   always_comb begin
      unique case (opcode)
         OPC_REG:  ctrl = reg_ctrl;
         OPC_ADDI: ctrl = '{op: XOP_ADD,  bsrc: BSRC_SEXT};
         OPC_SLTI: ctrl = '{op: XOP_SLT,  bsrc: BSRC_SEXT};
         OPC_ANDI: ctrl = '{op: XOP_AND,  bsrc: BSRC_ZEXT};
         OPC_ORI:  ctrl = '{op: XOP_OR,   bsrc: BSRC_ZEXT};
         OPC_LUI:  ctrl = '{op: XOP_HIGH, bsrc: BSRC_ZEXT};
         default:  ctrl = '{op: XOP_NONE, bsrc: BSRC_REG};
      endcase
   end

endmodule

// File: rtl/exec_alu_arith.sv
module exec_alu_arith #(
   parameter int DATA_W        = 32,
   parameter bit CMP_FROM_DIFF = 1'b1
) (
   input  logic              do_sub,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic [DATA_W-1:0] sum,
   output logic              less
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] diff;
   logic [DATA_W-1:0] plus;

   assign plus = opa + opb;
   assign diff = opa - opb;
   assign sum  = do_sub ? diff : plus;

   generate
      if (CMP_FROM_DIFF) begin : g_cmp_diff
         // Opposite signs: the negative one is smaller; same signs: no overflow.
         assign less = (opa[MSB] ^ opb[MSB]) ? opa[MSB] : diff[MSB];
      end else begin : g_cmp_signed
         assign less = $signed(opa) < $signed(opb);
      end
   endgenerate

endmodule

// File: rtl/exec_alu_logic.sv
module exec_alu_logic
   import exec_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  xop_e              op,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic [DATA_W-1:0] out
);

   logic [DATA_W-1:0] any_set;

   assign any_set = opa | opb;

   always_comb begin
      unique case (op)
         XOP_AND: out = opa & opb;
         XOP_OR:  out = any_set;
         XOP_NOR: out = ~any_set;
         default: out = '0;
      endcase
   end

endmodule

// File: rtl/exec_alu_shift.sv
module exec_alu_shift #(
   parameter int DATA_W     = 32,
   parameter bit LOG_STAGES = 1'b1,
   localparam int SH_W      = $clog2(DATA_W)
) (
   input  logic              go_right,
   input  logic [DATA_W-1:0] src,
   input  logic [SH_W-1:0]   amount,
   output logic [DATA_W-1:0] out
);

   logic [DATA_W-1:0] left_out;
   logic [DATA_W-1:0] right_out;

   generate
      if (LOG_STAGES) begin : g_log
         logic [SH_W:0][DATA_W-1:0] lst;
         logic [SH_W:0][DATA_W-1:0] rst_st;
         assign lst[0]    = src;
         assign rst_st[0] = src;
         for (genvar s = 0; s < SH_W; s++) begin : g_stage
            localparam int STEP = 1 << s;
            assign lst[s+1] = amount[s]
               ? {lst[s][DATA_W-1-STEP:0], {STEP{1'b0}}}
               : lst[s];
            assign rst_st[s+1] = amount[s]
               ? {{STEP{1'b0}}, rst_st[s][DATA_W-1:STEP]}
               : rst_st[s];
         end
         assign left_out  = lst[SH_W];
         assign right_out = rst_st[SH_W];
      end else begin : g_direct
         assign left_out  = src << amount;
         assign right_out = src >> amount;
      end
   endgenerate

   assign out = go_right ? right_out : left_out;

endmodule

// File: rtl/exec_alu_core.sv
module exec_alu_core
   import exec_alu_pkg::*;
#(
   parameter int DATA_W          = 32,
   parameter int IMM_W           = 16,
   parameter bit SHIFT_LOG       = 1'b1,
   parameter bit CMP_FROM_DIFF   = 1'b1,
   localparam int SH_W           = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [5:0]        opcode,
   input  logic [5:0]        funct,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [SH_W-1:0]   shamt,
   input  logic [IMM_W-1:0]  imm,
   output logic [DATA_W-1:0] result_q,
   output logic              zero_q
);

   localparam int EXT_W = DATA_W - IMM_W;

   generate
      if (DATA_W < 2 || (1 << SH_W) != DATA_W) begin : g_bad_width
         $error("exec_alu_core: DATA_W must be a power of two");
      end
      if (IMM_W < 1 || IMM_W >= DATA_W) begin : g_bad_imm
         $error("exec_alu_core: IMM_W must be between 1 and DATA_W-1");
      end
   endgenerate

   xctrl_t            ctrl;
   logic [DATA_W-1:0] opb;
   logic [DATA_W-1:0] arith_sum;
   logic              arith_less;
   logic [DATA_W-1:0] logic_out;
   logic [DATA_W-1:0] shift_out;
   logic [DATA_W-1:0] result_d;

   exec_alu_decode u_decode (
      .opcode (opcode),
      .funct  (funct),
      .ctrl   (ctrl)
   );

   always_comb begin
      unique case (ctrl.bsrc)
         BSRC_SEXT: opb = {{EXT_W{imm[IMM_W-1]}}, imm};
         BSRC_ZEXT: opb = {{EXT_W{1'b0}}, imm};
         default:   opb = src_b;
      endcase
   end

   exec_alu_arith #(
      .DATA_W        (DATA_W),
      .CMP_FROM_DIFF (CMP_FROM_DIFF)
   ) u_arith (
      .do_sub (ctrl.op == XOP_SUB),
      .opa    (src_a),
      .opb    (opb),
      .sum    (arith_sum),
      .less   (arith_less)
   );

   exec_alu_logic #(
      .DATA_W (DATA_W)
   ) u_logic (
      .op  (ctrl.op),
      .opa (src_a),
      .opb (opb),
      .out (logic_out)
   );

   exec_alu_shift #(
      .DATA_W     (DATA_W),
      .LOG_STAGES (SHIFT_LOG)
   ) u_shift (
      .go_right (ctrl.op == XOP_SRL),
      .src      (src_b),
      .amount   (shamt),
      .out      (shift_out)
   );

   always_comb begin
      unique case (ctrl.op)
         XOP_ADD, XOP_SUB:         result_d = arith_sum;
         XOP_SLT:                  result_d = {{(DATA_W-1){1'b0}}, arith_less};
         XOP_AND, XOP_OR, XOP_NOR: result_d = logic_out;
         XOP_SLL, XOP_SRL:         result_d = shift_out;
         XOP_HIGH:                 result_d = {imm, {EXT_W{1'b0}}};
         default:                  result_d = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         result_q <= '0;
         zero_q   <= 1'b1;
      end else begin
         result_q <= result_d;
         zero_q   <= (result_d == '0);
      end
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (result_q == '0 && zero_q));

   // R9
   zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
      zero_q == (result_q == '0));

   // R4
   slt_range_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(opcode == OPC_REG && funct == FN_SLT))
      |-> (result_q[DATA_W-1:1] == '0));

   // R8
   high_low_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(opcode == OPC_LUI))
      |-> (result_q[EXT_W-1:0] == '0 && result_q[DATA_W-1:EXT_W] == $past(imm)));

   // R6
   addi_sum_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(opcode == OPC_ADDI))
      |-> (result_q == $past(src_a + {{EXT_W{imm[IMM_W-1]}}, imm})));

   // R11
   undefined_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(ctrl.op == XOP_NONE)) |-> (result_q == '0 && zero_q));

endmodule

// File: tb/exec_alu_core_test.sv
module exec_alu_core_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [5:0]  opcode = '0;
   logic [5:0]  funct = '0;
   logic [31:0] src_a = '0;
   logic [31:0] src_b = '0;
   logic [4:0]  shamt = '0;
   logic [15:0] imm = '0;
   logic [31:0] res_main, res_alt;
   logic        zf_main, zf_alt;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   exec_alu_core uut (
      .clk(clk), .rst(rst), .opcode(opcode), .funct(funct),
      .src_a(src_a), .src_b(src_b), .shamt(shamt), .imm(imm),
      .result_q(res_main), .zero_q(zf_main)
   );

   exec_alu_core #(.SHIFT_LOG(1'b0), .CMP_FROM_DIFF(1'b0)) uut_alt (
      .clk(clk), .rst(rst), .opcode(opcode), .funct(funct),
      .src_a(src_a), .src_b(src_b), .shamt(shamt), .imm(imm),
      .result_q(res_alt), .zero_q(zf_alt)
   );

   function automatic logic [31:0] model(input logic [5:0] opc, input logic [5:0] fn,
                                         input logic [31:0] a, input logic [31:0] b,
                                         input logic [4:0] sh, input logic [15:0] im);
      logic [31:0] sx, zx;
      sx = {{16{im[15]}}, im};
      zx = {16'h0000, im};
      case (opc)
         6'd0: case (fn)
            6'd32:   return a + b;
            6'd34:   return a - b;
            6'd36:   return a & b;
            6'd37:   return a | b;
            6'd39:   return ~(a | b);
            6'd42:   return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            6'd0:    return b << sh;
            6'd2:    return b >> sh;
            default: return 32'd0;
         endcase
         6'd8:    return a + sx;
         6'd10:   return ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
         6'd12:   return a & zx;
         6'd13:   return a | zx;
         6'd15:   return {im, 16'h0000};
         default: return 32'd0;
      endcase
   endfunction

   function automatic string tag_of(input logic [5:0] opc, input logic [5:0] fn);
      case (opc)
         6'd0: case (fn)
            6'd32, 6'd34:        return "R2";
            6'd36, 6'd37, 6'd39: return "R3";
            6'd42:               return "R4";
            6'd0, 6'd2:          return "R5";
            default:             return "R11";
         endcase
         6'd8, 6'd10:  return "R6";
         6'd12, 6'd13: return "R7";
         6'd15:        return "R8";
         default:      return "R11";
      endcase
   endfunction

   task automatic check_out(input string req, input logic [31:0] exp_r);
      logic exp_z;
      exp_z = (exp_r == 32'd0);
      checks++;
      if (res_main !== exp_r || zf_main !== exp_z) begin
         errors++;
         $display("FAIL %s main: result=%h zero=%b expected result=%h zero=%b",
                  req, res_main, zf_main, exp_r, exp_z);
      end
      checks++;
      if (res_alt !== exp_r || zf_alt !== exp_z) begin
         errors++;
         $display("FAIL %s alt: result=%h zero=%b expected result=%h zero=%b",
                  req, res_alt, zf_alt, exp_r, exp_z);
      end
   endtask

   // Drive at a falling edge, capture at the rising edge, sample at the next falling edge (R10).
   task automatic run_op(input logic [5:0] opc, input logic [5:0] fn,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] sh, input logic [15:0] im, input string req);
      @(negedge clk);
      opcode = opc; funct = fn; src_a = a; src_b = b; shamt = sh; imm = im;
      @(negedge clk);
      check_out(req, model(opc, fn, a, b, sh, im));
   endtask

   localparam logic [11:0] VALID [14] = '{
      {6'd0, 6'd32}, {6'd0, 6'd34}, {6'd0, 6'd36}, {6'd0, 6'd37}, {6'd0, 6'd39},
      {6'd0, 6'd42}, {6'd0, 6'd0},  {6'd0, 6'd2},  {6'd8, 6'd0},  {6'd10, 6'd0},
      {6'd12, 6'd0}, {6'd13, 6'd0}, {6'd15, 6'd0}, {6'd4, 6'd0}
   };

   initial begin
      void'($urandom(32'h1A2B3C4D));
      // R1: reset state
      opcode = 6'd0; funct = 6'd32; src_a = 32'd5; src_b = 32'd6;
      repeat (2) @(negedge clk);
      check_out("R1", 32'd0);
      rst = 1'b0;

      // R2 directed
      run_op(6'd0, 6'd32, 32'h7FFF_FFFF, 32'd1, 5'd0, 16'h0, "R2");
      run_op(6'd0, 6'd32, 32'hFFFF_FFFF, 32'd1, 5'd0, 16'h0, "R2");
      run_op(6'd0, 6'd34, 32'h1234_5678, 32'h1234_5678, 5'd0, 16'h0, "R2 R9");
      run_op(6'd0, 6'd34, 32'd0, 32'd1, 5'd0, 16'h0, "R2");
      // R3 directed
      run_op(6'd0, 6'd39, 32'd0, 32'd0, 5'd0, 16'h0, "R3");
      run_op(6'd0, 6'd39, 32'hF0F0_0000, 32'h0F0F_0000, 5'd0, 16'h0, "R3");
      run_op(6'd0, 6'd36, 32'hFF00_FF00, 32'h0FF0_0FF0, 5'd0, 16'h0, "R3");
      // R4 directed, including opposite-sign overflow cases
      run_op(6'd0, 6'd42, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, 16'h0, "R4");
      run_op(6'd0, 6'd42, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0, 16'h0, "R4");
      run_op(6'd0, 6'd42, 32'd3, 32'd3, 5'd0, 16'h0, "R4");
      // R5 directed: src_a must not matter
      run_op(6'd0, 6'd0, 32'hFFFF_FFFF, 32'h0000_0003, 5'd31, 16'h0, "R5");
      run_op(6'd0, 6'd2, 32'hDEAD_BEEF, 32'h8000_0001, 5'd31, 16'h0, "R5");
      run_op(6'd0, 6'd2, 32'd0, 32'hA5A5_A5A5, 5'd0, 16'h0, "R5");
      // R6 directed
      run_op(6'd8, 6'd0, 32'd5, 32'd0, 5'd0, 16'hFFFB, "R6");
      run_op(6'd10, 6'd0, 32'hFFFF_FFFE, 32'd0, 5'd0, 16'hFFFF, "R6");
      run_op(6'd10, 6'd0, 32'd0, 32'd0, 5'd0, 16'h8000, "R6");
      // R7 directed
      run_op(6'd12, 6'd0, 32'hFFFF_FFFF, 32'd0, 5'd0, 16'h8000, "R7");
      run_op(6'd13, 6'd0, 32'h1200_0000, 32'd0, 5'd0, 16'hFFFF, "R7");
      // R8 directed
      run_op(6'd15, 6'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, 16'd255, "R8");
      run_op(6'd15, 6'd0, 32'd0, 32'd0, 5'd0, 16'h0000, "R8 R9");
      // R11 directed
      run_op(6'd0, 6'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd7, 16'hFFFF, "R11");
      run_op(6'd4, 6'd32, 32'd1, 32'd2, 5'd0, 16'h1234, "R11");

      // R1 mid-run
      @(negedge clk);
      rst = 1'b1; opcode = 6'd0; funct = 6'd37; src_a = 32'hFFFF; src_b = 32'd1;
      @(negedge clk);
      check_out("R1", 32'd0);
      rst = 1'b0;

      // Random mix: R10 plus each operation's requirement
      for (int n = 0; n < 400; n++) begin
         logic [11:0] pick;
         logic [5:0]  ro, rf;
         pick = VALID[$urandom_range(0, 13)];
         ro = pick[11:6];
         rf = pick[5:0];
         if ($urandom_range(0, 9) == 0) begin
            ro = 6'($urandom);
            rf = 6'($urandom);
         end
         run_op(ro, rf, $urandom, ($urandom_range(0, 7) == 0) ? 32'd0 : $urandom,
                5'($urandom), 16'($urandom), tag_of(ro, rf));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule